// File: doc/BRIEF.md
# GPIO Interrupt Detector with Glitch Filter

This block watches thirteen general-purpose input pins and raises an interrupt when one of them shows a programmed condition that lasts long enough to be trusted. Each pin is first brought into the bus clock domain through a two-flop synchronizer. A 3-bit detect type, held per pin, chooses what counts: a high level, a low level, a rising edge, a falling edge, or an edge in either direction. A small per-pin counter then requires that condition to last four consecutive clock cycles before the pin's status bit is set, so short pulses and glitches are dropped in every mode.

Status bits are sticky and are cleared by writing ones through a mask. When a set and a clear land in the same cycle, the set wins. The interrupt output is the registered OR of all status bits. Software programs a pin's type by giving the pin index and the 3-bit code on a single-cycle write strobe. Writing a pin's type also restarts that pin's detection.

Top module: `gpio_irq_detect`

## Requirements
- R1: After synchronous reset, `sts_o` is all zero, `irq_o` is 0, and every pin's detect type is 111 (disabled), so pin activity sets no status until a type is written.
- R2: A pin passes through two synchronizer flops. In the level-high type, a pin first sampled high at clock edge e0 and held high sets its status bit at edge e5 and not before.
- R3: The type codes are 000 level high, 001 level low, 010 rising edge, 011 falling edge and 100 either edge. The codes 101, 110 and 111 disable detection on that pin.
- R4: In the level-high type, the status bit is set only once the synchronized input has been 1 for four consecutive cycles. A pulse of three cycles or less sets nothing.
- R5: In the level-low type, the status bit is set only once the synchronized input has been 0 for four consecutive cycles. A shorter low pulse sets nothing.
- R6: In both level types, the status bit is set again on every cycle that the condition keeps holding past four cycles, so a clear written during that time does not remove it.
- R7: In the rising type, a 0-to-1 transition whose new level holds for four cycles (the transition cycle included) sets the status bit exactly once. Holding the level longer does not set it again, and a falling transition sets nothing.
- R8: In the falling type, a 1-to-0 transition whose new level holds for four cycles sets the status bit exactly once.
- R9: In the either-edge type, a transition in either direction whose new level holds for four cycles sets the status bit.
- R10: In the edge types, if the synchronized level reverts before the fourth cycle, the pending detection is discarded and no status is set.
- R11: Status bits are sticky. When `clr_we_i` is high, each bit whose `clr_mask_i` bit is 1 is cleared and all other bits are kept. A set in the same cycle overrides the clear.
- R12: `irq_o` is registered and always equals the OR of `sts_o`.
- R13: Writing a pin's type clears that pin's progress. A condition already under way must then last four further cycles after the write edge before the status bit is set.
- R14: Each pin's detection is independent of the other pins' inputs and types.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_PINS | Raw asynchronous pin inputs |
| cfg_we_i | input | 1 | Single-cycle strobe that writes a detect type |
| cfg_pin_i | input | SEL_W | Index of the pin whose type is written |
| cfg_type_i | input | 3 | Detect type code (R3) |
| clr_we_i | input | 1 | Strobe that applies the clear mask |
| clr_mask_i | input | NUM_PINS | Ones select the status bits to clear |
| sts_o | output | NUM_PINS | Sticky per-pin status bits |
| irq_o | output | 1 | Registered OR of all status bits |

## Verification
The assertions assume that `cfg_pin_i` names an existing pin whenever `cfg_we_i` is high, and that reset is held for at least two cycles so that the synchronizer chain is known before it is compared with its own past. The stimulus only writes pins 0 to 12 and holds reset for four cycles. The pin inputs may change freely, because the assertions only look at signals after the synchronizer. The directed phases keep each pin's type fixed while its pulses are in flight, except in the one test that deliberately rewrites a type during a count. The random phase rewrites types only at sparse intervals.

// File: rtl/gid_pkg.sv
package gid_pkg;
  localparam int TYPE_W = 3;

  typedef enum logic [TYPE_W-1:0] {
    DET_HIGH = 3'd0,
    DET_LOW  = 3'd1,
    DET_RISE = 3'd2,
    DET_FALL = 3'd3,
    DET_ANY  = 3'd4,
    DET_OFF  = 3'd7
  } det_e;
endpackage

// File: rtl/gid_sync.sv
module gid_sync #(
  parameter int WIDTH  = 13,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];
  logic             live_q;

  always_ff @(posedge clk) begin
    if (rst) live_q <= 1'b0;
    else     live_q <= 1'b1;
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
      // R2: each stage carries the previous stage's value one cycle later
      assert_chain_shift_R2: assert property (@(posedge clk) disable iff (rst || !live_q)
        chain[s] == $past(chain[s-1]));
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/gid_pin_det.sv
module gid_pin_det
  import gid_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_i,
  input  logic              cfg_we_i,
  input  logic [TYPE_W-1:0] cfg_type_i,
  output logic              hit_o
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(WIDTH);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIDTH - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [TYPE_W-1:0] type_q;
  logic              prev_q;
  logic              armed_q;
  logic              lvl_q;
  logic [CNT_W-1:0]  cnt_q;

  logic is_level, cond, changed, qual, hit_lvl, hit_edge;

  always_comb begin
    is_level = (type_q == DET_HIGH) || (type_q == DET_LOW);
    cond     = (type_q == DET_HIGH) ? sync_i : ~sync_i;
    changed  = sync_i ^ prev_q;
    qual     = changed && (((type_q == DET_RISE) && sync_i) ||
                           ((type_q == DET_FALL) && !sync_i) ||
                            (type_q == DET_ANY));
    hit_lvl  = is_level && cond && (cnt_q >= CNT_LAST);
    hit_edge = armed_q && !qual && (sync_i == lvl_q) && (cnt_q == CNT_LAST);
    hit_o    = hit_lvl || hit_edge;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      type_q  <= DET_OFF;
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
      lvl_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      prev_q <= sync_i;
      if (cfg_we_i) begin
        type_q  <= cfg_type_i;
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else if (is_level) begin
        armed_q <= 1'b0;
        if (!cond)                cnt_q <= '0;
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
      end else if (qual) begin
        armed_q <= 1'b1;
        lvl_q   <= sync_i;
        cnt_q   <= CNT_ONE;
      end else if (armed_q && (sync_i == lvl_q) && (cnt_q != CNT_LAST)) begin
        cnt_q <= cnt_q + CNT_ONE;
      end else begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end
    end
  end

  // R4: the width counter saturates and never passes the required width
  assert_cnt_cap_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_MAX);
  // R10: a detection only fires while the synchronized level is steady
  assert_hit_steady_R10: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (sync_i == prev_q));
  // R3: a disabled pin holds no detection progress
  assert_off_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (type_q > 3'd4) |-> (cnt_q == '0 && !armed_q));
  // R7: an edge detection fires once, not on the following cycle
  assert_edge_once_R7: assert property (@(posedge clk) disable iff (rst)
    (hit_o && !is_level) |=> !hit_o);
endmodule

// File: rtl/gid_status.sv
module gid_status #(
  parameter int NUM_PINS = 13
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] hit_i,
  input  logic                clr_we_i,
  input  logic [NUM_PINS-1:0] clr_mask_i,
  output logic [NUM_PINS-1:0] sts_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] clr_eff, sts_nxt;

  always_comb begin
    clr_eff = clr_we_i ? clr_mask_i : '0;
    sts_nxt = (sts_o & ~clr_eff) | hit_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_o <= '0;
      irq_o <= 1'b0;
    end else begin
      sts_o <= sts_nxt;
      irq_o <= |sts_nxt;
    end
  end

  // R11: bits not selected for clearing are never lost
  assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(sts_o) & ~$past(clr_eff)) & ~sts_o) == '0));
  // R11: a detection sets its bit even when a clear arrives in the same cycle
  assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (|hit_i) |=> ((sts_o & $past(hit_i)) == $past(hit_i)));
  // R12: the interrupt follows the status bits
  assert_irq_or_R12: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|sts_o));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gid_pkg::*;
#(
  parameter int NUM_PINS    = 13,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_WIDTH   = 4,
  parameter int SEL_W       = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                cfg_we_i,
  input  logic [SEL_W-1:0]    cfg_pin_i,
  input  logic [TYPE_W-1:0]   cfg_type_i,
  input  logic                clr_we_i,
  input  logic [NUM_PINS-1:0] clr_mask_i,
  output logic [NUM_PINS-1:0] sts_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] hit;

  gid_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (pin_i),
    .dout(pin_sync)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic sel_we;
    assign sel_we = cfg_we_i && (cfg_pin_i == SEL_W'(g));
    gid_pin_det #(.WIDTH(MIN_WIDTH)) u_det (
      .clk       (clk),
      .rst       (rst),
      .sync_i    (pin_sync[g]),
      .cfg_we_i  (sel_we),
      .cfg_type_i(cfg_type_i),
      .hit_o     (hit[g])
    );
  end

  gid_status #(.NUM_PINS(NUM_PINS)) u_status (
    .clk       (clk),
    .rst       (rst),
    .hit_i     (hit),
    .clr_we_i  (clr_we_i),
    .clr_mask_i(clr_mask_i),
    .sts_o     (sts_o),
    .irq_o     (irq_o)
  );
endmodule

// File: tb/test_gpio_irq_detect.sv
module test_gpio_irq_detect;
  localparam int NP = 13;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pin = '0;
  logic          cfg_we = 1'b0;
  logic [SW-1:0] cfg_pin = '0;
  logic [2:0]    cfg_type = '0;
  logic          clr_we = 1'b0;
  logic [NP-1:0] clr_mask = '0;
  logic [NP-1:0] sts;
  logic          irq;

  always #5 clk = ~clk;

  gpio_irq_detect i_gpio_irq_detect (
    .clk(clk), .rst(rst), .pin_i(pin), .cfg_we_i(cfg_we), .cfg_pin_i(cfg_pin),
    .cfg_type_i(cfg_type), .clr_we_i(clr_we), .clr_mask_i(clr_mask),
    .sts_o(sts), .irq_o(irq)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    model_on = 1'b0;
  bit    finished = 1'b0;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: run lengths and ages instead of counters
  int            m_s1 [NP];
  int            m_s2 [NP];
  int            m_last [NP];
  int            m_run [NP];
  int            m_age [NP];
  int            m_type [NP];
  bit            m_est [NP];
  logic [NP-1:0] m_sts = '0;
  logic          m_irq = 1'b0;
  logic [NP-1:0] m_hit;

  always @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NP; p++) begin
        m_s1[p] = 0; m_s2[p] = 0; m_last[p] = 0; m_run[p] = 0;
        m_age[p] = 0; m_type[p] = 7; m_est[p] = 1'b0;
      end
      m_sts = '0;
      m_irq = 1'b0;
    end else begin
      m_hit = '0;
      for (int p = 0; p < NP; p++) begin
        int cur;
        int eff;
        cur = m_s2[p];
        if (cur == m_last[p]) m_run[p]++;
        else begin m_run[p] = 1; m_est[p] = 1'b1; end
        m_age[p]++;
        eff = (m_run[p] < m_age[p]) ? m_run[p] : m_age[p];
        case (m_type[p])
          0: m_hit[p] = (cur == 1) && (eff >= 4);
          1: m_hit[p] = (cur == 0) && (eff >= 4);
          2: m_hit[p] = (cur == 1) && m_est[p] && (m_run[p] == 4) && (m_age[p] >= 4);
          3: m_hit[p] = (cur == 0) && m_est[p] && (m_run[p] == 4) && (m_age[p] >= 4);
          4: m_hit[p] = m_est[p] && (m_run[p] == 4) && (m_age[p] >= 4);
          default: m_hit[p] = 1'b0;
        endcase
        if (cfg_we && (int'(cfg_pin) == p)) begin
          m_type[p] = int'(cfg_type);
          m_age[p]  = 0;
        end
        m_last[p] = cur;
        m_s2[p]   = m_s1[p];
        m_s1[p]   = int'(pin[p]);
      end
      m_sts = (m_sts & ~(clr_we ? clr_mask : '0)) | m_hit;
      m_irq = |m_sts;
    end
  end

  always @(negedge clk) begin
    if (model_on && !rst) begin
      check({cur_req, " model sts"}, int'(sts), int'(m_sts));
      check("R12 model irq", int'(irq), int'(m_irq));
    end
  end

  task automatic cfg(int p, int t);
    @(negedge clk);
    cfg_we = 1'b1; cfg_pin = SW'(p); cfg_type = 3'(t);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clr(logic [NP-1:0] m);
    @(negedge clk);
    clr_we = 1'b1; clr_mask = m;
    @(negedge clk);
    clr_we = 1'b0; clr_mask = '0;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] rs = 32'h1234_5679;
  function automatic logic [31:0] step(logic [31:0] v);
    logic [31:0] x;
    x = v;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    model_on = 1'b1;
    @(negedge clk);
    check("R1 sts after reset", int'(sts), 0);
    check("R1 irq after reset", int'(irq), 0);

    // R1/R3: default type is disabled
    cur_req = "R1";
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); pin = '1; wait_n(8);
      pin = '0; wait_n(8);
    end
    check("R1 no status with default type", int'(sts), 0);

    // R2/R4/R6/R11 on pin 0, level high
    cur_req = "R2";
    cfg(0, 0);
    wait_n(3);
    pin[0] = 1'b1;
    wait_n(5);
    check("R2 not yet at edge e4", int'(sts[0]), 0);
    wait_n(1);
    check("R2 set at edge e5", int'(sts[0]), 1);
    check("R12 irq follows", int'(irq), 1);
    cur_req = "R6";
    wait_n(2);
    clr(13'h0001);
    check("R6 held level re-sets", int'(sts[0]), 1);
    @(negedge clk); pin[0] = 1'b0;
    wait_n(6);
    clr(13'h0001);
    check("R11 cleared", int'(sts[0]), 0);
    cur_req = "R4";
    pin[0] = 1'b1; wait_n(3); pin[0] = 1'b0;
    wait_n(10);
    check("R4 three-cycle pulse ignored", int'(sts[0]), 0);

    // R5 on pin 1, level low
    cur_req = "R5";
    pin[1] = 1'b1; wait_n(4);
    cfg(1, 1);
    wait_n(4);
    pin[1] = 1'b0; wait_n(2); pin[1] = 1'b1;
    wait_n(10);
    check("R5 short low ignored", int'(sts[1]), 0);
    pin[1] = 1'b0; wait_n(5); pin[1] = 1'b1;
    wait_n(8);
    check("R5 long low sets", int'(sts[1]), 1);
    clr(13'h0002);
    wait_n(2);
    check("R5 cleared after release", int'(sts[1]), 0);

    // R7/R10 on pin 2, rising
    cur_req = "R7";
    cfg(2, 2);
    wait_n(2);
    pin[2] = 1'b1; wait_n(8);
    check("R7 rising sets", int'(sts[2]), 1);
    clr(13'h0004);
    wait_n(8);
    check("R7 no re-set while held", int'(sts[2]), 0);
    pin[2] = 1'b0; wait_n(8);
    check("R7 falling ignored", int'(sts[2]), 0);
    cur_req = "R10";
    pin[2] = 1'b1; wait_n(3); pin[2] = 1'b0;
    wait_n(10);
    check("R10 revert discards", int'(sts[2]), 0);

    // R8 on pin 3, falling
    cur_req = "R8";
    cfg(3, 3);
    wait_n(2);
    pin[3] = 1'b1; wait_n(8);
    check("R8 rising ignored", int'(sts[3]), 0);
    pin[3] = 1'b0; wait_n(8);
    check("R8 falling sets", int'(sts[3]), 1);

    // R9 on pin 4, either edge
    cur_req = "R9";
    cfg(4, 4);
    wait_n(2);
    pin[4] = 1'b1; wait_n(8);
    check("R9 rise sets", int'(sts[4]), 1);
    clr(13'h0010);
    wait_n(2);
    check("R9 cleared", int'(sts[4]), 0);
    pin[4] = 1'b0; wait_n(8);
    check("R9 fall sets", int'(sts[4]), 1);

    // R11 set wins over clear, mask keeps other bits
    cur_req = "R11";
    cfg(5, 0);
    wait_n(2);
    pin[5] = 1'b1;
    wait_n(4);
    pin[5] = 1'b0;
    wait_n(1);
    clr_we = 1'b1; clr_mask = 13'h0028;
    @(negedge clk);
    clr_we = 1'b0; clr_mask = '0;
    check("R11 set wins", int'(sts[5]), 1);
    check("R11 masked bit cleared", int'(sts[3]), 0);
    check("R11 unmasked bit kept", int'(sts[4]), 1);

    // R13 type rewrite restarts a count
    cur_req = "R13";
    cfg(6, 0);
    wait_n(2);
    pin[6] = 1'b1;
    wait_n(2);
    cfg_we = 1'b1; cfg_pin = SW'(6); cfg_type = 3'd0;
    @(negedge clk);
    cfg_we = 1'b0;
    wait_n(3);
    check("R13 no set at e5 after restart", int'(sts[6]), 0);
    wait_n(1);
    check("R13 set at e6", int'(sts[6]), 1);
    pin[6] = 1'b0;

    // R3 invalid code disables pin 7
    cur_req = "R3";
    cfg(7, 5);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); pin[7] = 1'b1; wait_n(8);
      pin[7] = 1'b0; wait_n(8);
    end
    check("R3 code 101 disables", int'(sts[7]), 0);

    // R14 random phase against the model
    cur_req = "R14";
    for (int p = 0; p < NP; p++) cfg(p, (p % 7 == 5) ? 6 : (p % 7 == 6) ? 7 : p % 7);
    clr('1);
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      for (int p = 0; p < NP; p++) begin
        rs = step(rs);
        if (rs[2:0] == 3'd0) pin[p] = ~pin[p];
      end
      rs = step(rs);
      clr_we   = (rs[3:0] == 4'd0);
      clr_mask = rs[16:4];
      cfg_we   = 1'b0;
      if ((c % 250) == 249) begin
        rs = step(rs);
        cfg_we   = 1'b1;
        cfg_pin  = SW'(rs[7:0] % NP);
        cfg_type = rs[10:8];
      end
    end
    @(negedge clk);
    clr_we = 1'b0; cfg_we = 1'b0;
    wait_n(4);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule